// File: doc/BRIEF.md
# Circular Command Queue Consumer

This block drains a ring of fixed-size command records that software places in system memory. Software owns the write index and the enable bit. Whenever the unit is enabled, not halted, and the write index differs from the read index, the block does the following for each record. It fetches the first 64-bit word over a request/acknowledge read port and takes the opcode from that word. It then either hands the record's byte offset to an external handler or retires the record at once. After that it moves the read index forward, wrapping at the configured ring size.

Processing starts on two events: a write-index update that leaves the write index different from the read index, or the enable bit going from 0 to 1. Turning the unit on zeroes the read index first. If either index is beyond the configured entry count, the pass ends without consuming anything. A failed memory read or a failed handler sets a sticky halt flag and leaves the read index on the failing record. Software clears the halt by rewriting the read index.

Top module: `cmdq_consumer`

## Requirements
- R1: After reset the enable bit, write index, read index, halt flag, busy, memory request and handler start are all 0.
- R2: No record is fetched while enable is 0. While enabled, a write-index update whose value differs from the read index starts a pass. An update equal to the read index fetches nothing.
- R3: Writing enable from 0 to 1 sets the read index to 0 and clears the halt flag on the next clock, then starts a pass.
- R4: Each record is 32 bytes. The fetch address is the read index times 32. memReq stays high until the cycle in which memAck is seen.
- R5: The opcode is bits [7:0] of memData. Opcode 0x08 raises hStart for exactly one cycle with hSel=0, and opcode 0x09 does the same with hSel=1. In both cases hOffset equals the record's byte offset (read index times 32).
- R6: Every other opcode (for example 0x03, 0x04, 0x05, 0x0C, 0x0D, 0x0F, 0xFF) retires without any hStart.
- R7: After a record retires, the read index becomes (read index + 1) modulo cfgMaxEntries.
- R8: A pass continues until the read index equals the write index. busy is 1 for the whole pass.
- R9: If the write index or the read index is greater than cfgMaxEntries, the pass ends with no fetch and with the read index unchanged.
- R10: A fetch that returns memErr=1 with memAck sets the halt flag and ends the pass. The read index stays on the failing record.
- R11: A hDone that arrives with hErr=1 sets the halt flag and ends the pass. The read index stays on the failing record.
- R12: The halt flag stays set until reset, a read-index write or an enable rising edge. While it is set no record is fetched. A read-index write loads the new index and clears the flag, and a trigger held during the halt then runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swEnWr | input | 1 | Strobe: write the enable bit |
| swEnVal | input | 1 | Enable value to write |
| swWrPtrWr | input | 1 | Strobe: write the write index |
| swWrPtrVal | input | IDX_W | New write index |
| swRdPtrWr | input | 1 | Strobe: write the read index (clears halt) |
| swRdPtrVal | input | IDX_W | New read index |
| cfgMaxEntries | input | IDX_W | Ring size in records |
| enable | output | 1 | Enable bit |
| wrIdx | output | IDX_W | Write index |
| rdIdx | output | IDX_W | Read index |
| stalled | output | 1 | Sticky halt flag |
| busy | output | 1 | A pass is in progress |
| memReq | output | 1 | Read request, held until memAck |
| memAddr | output | IDX_W+5 | Byte offset of the record being read |
| memAck | input | 1 | Read acknowledge |
| memErr | input | 1 | Read failed, valid with memAck |
| memData | input | 64 | First word of the record, valid with memAck |
| hStart | output | 1 | One-cycle handler start |
| hSel | output | 1 | Handler select: 0 device map, 1 collection map |
| hOffset | output | IDX_W+5 | Byte offset of the record for the handler |
| hDone | input | 1 | Handler finished |
| hErr | input | 1 | Handler failed, valid with hDone |

## Verification
Bad internal state appears at the ports within a few cycles. A wrong wrap or a wrong increment leaves rdIdx on the wrong value once busy drops. A stuck or dropped halt flag shows up as fetches that should not happen, or that are missing, on the next trigger. A decode fault shows up as the wrong count or selection of hStart pulses, and as the wrong hOffset. The bench compares every fetched address and every handler start against the sequence it predicts from the indices.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int ENTRY_BYTES = 32;
  localparam int OFF_W = $clog2(ENTRY_BYTES);

  localparam logic [7:0] OP_MAP_DEV  = 8'h08;
  localparam logic [7:0] OP_MAP_COLL = 8'h09;

  // strobes from control to datapath
  typedef struct packed {
    logic clrRun;
    logic latchOp;
    logic advance;
    logic setStall;
  } strb_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_FETCH, S_CALL, S_WAIT, S_NEXT
  } state_t;
endpackage

// File: rtl/cmdq_dpath.sv
module cmdq_dpath import cmdq_pkg::*; #(
  parameter int IDX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   swEnWr,
  input  logic                   swEnVal,
  input  logic                   swWrPtrWr,
  input  logic [IDX_W-1:0]       swWrPtrVal,
  input  logic                   swRdPtrWr,
  input  logic [IDX_W-1:0]       swRdPtrVal,
  input  logic [IDX_W-1:0]       cfgMaxEntries,
  input  strb_t                  strb,
  input  logic [63:0]            memData,
  output logic                   enable,
  output logic [IDX_W-1:0]       wrIdx,
  output logic [IDX_W-1:0]       rdIdx,
  output logic                   stalled,
  output logic                   runReq,
  output logic                   outOfRange,
  output logic                   qEmpty,
  output logic                   opHandled,
  output logic                   opSel,
  output logic [IDX_W+OFF_W-1:0] entryOff
);
  localparam int ADDR_W = IDX_W + OFF_W;

  logic           enRise;
  logic [IDX_W:0] incIdx;
  logic [IDX_W:0] wrapIdx;

  assign enRise     = swEnWr && swEnVal && !enable;
  assign outOfRange = (wrIdx > cfgMaxEntries) || (rdIdx > cfgMaxEntries);
  assign qEmpty     = (wrIdx == rdIdx);
  assign opHandled  = (memData[7:0] == OP_MAP_DEV) || (memData[7:0] == OP_MAP_COLL);
  assign entryOff   = ADDR_W'({rdIdx, {OFF_W{1'b0}}});

  // modulo increment; a zero ring size parks the index at 0
  always_comb begin
    incIdx = {1'b0, rdIdx} + 1'b1;
    if (cfgMaxEntries == '0)
      wrapIdx = '0;
    else if (incIdx >= {1'b0, cfgMaxEntries})
      wrapIdx = incIdx - {1'b0, cfgMaxEntries};
    else
      wrapIdx = incIdx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable  <= 1'b0;
      wrIdx   <= '0;
      rdIdx   <= '0;
      stalled <= 1'b0;
      runReq  <= 1'b0;
      opSel   <= 1'b0;
    end else begin
      if (swEnWr) enable <= swEnVal;
      if (swWrPtrWr) wrIdx <= swWrPtrVal;

      if (enRise) begin
        rdIdx <= '0;
      end else if (swRdPtrWr) begin
        rdIdx <= swRdPtrVal;
      end else if (strb.advance) begin
        rdIdx <= wrapIdx[IDX_W-1:0];
      end

      if (enRise || swRdPtrWr) stalled <= 1'b0;
      else if (strb.setStall) stalled <= 1'b1;

      if (enRise || (swWrPtrWr && swWrPtrVal != rdIdx)) runReq <= 1'b1;
      else if (strb.clrRun) runReq <= 1'b0;

      if (strb.latchOp) opSel <= (memData[7:0] == OP_MAP_COLL);
    end
  end

  // R7
  wrap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.advance && cfgMaxEntries != '0 && !enRise && !swRdPtrWr
      |=> rdIdx < $past(cfgMaxEntries));

  // R12
  stall_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stalled && !enRise && !swRdPtrWr |=> stalled);

  // R10
  stall_holds_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.setStall && !enRise && !swRdPtrWr |=> $stable(rdIdx));
endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl import cmdq_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  logic  stalled,
  input  logic  runReq,
  input  logic  outOfRange,
  input  logic  qEmpty,
  input  logic  opHandled,
  input  logic  memAck,
  input  logic  memErr,
  input  logic  hDone,
  input  logic  hErr,
  output strb_t strb,
  output logic  memReq,
  output logic  hStart,
  output logic  busy
);
  state_t state, nextState;

  always_comb begin
    nextState = state;
    strb      = '0;
    memReq    = 1'b0;
    hStart    = 1'b0;
    unique case (state)
      S_IDLE: if (runReq && enable && !stalled) begin
        strb.clrRun = 1'b1;
        nextState   = S_CHECK;
      end
      S_CHECK: nextState = (!enable || outOfRange || qEmpty) ? S_IDLE : S_FETCH;
      S_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin
            strb.setStall = 1'b1;
            nextState     = S_IDLE;
          end else begin
            strb.latchOp = 1'b1;
            nextState    = opHandled ? S_CALL : S_NEXT;
          end
        end
      end
      S_CALL: begin
        hStart    = 1'b1;
        nextState = S_WAIT;
      end
      S_WAIT: if (hDone) begin
        if (hErr) begin
          strb.setStall = 1'b1;
          nextState     = S_IDLE;
        end else begin
          nextState = S_NEXT;
        end
      end
      S_NEXT: begin
        strb.advance = 1'b1;
        nextState    = S_CHECK;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nextState;
  end

  assign busy = (state != S_IDLE);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memReq && !memAck |=> memReq);

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hStart |=> !hStart);

  // R12
  no_fetch_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> !stalled);

  // R2
  no_fetch_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memReq) |-> $past(enable));
endmodule

// File: rtl/cmdq_consumer.sv
module cmdq_consumer import cmdq_pkg::*; #(
  parameter int IDX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   swEnWr,
  input  logic                   swEnVal,
  input  logic                   swWrPtrWr,
  input  logic [IDX_W-1:0]       swWrPtrVal,
  input  logic                   swRdPtrWr,
  input  logic [IDX_W-1:0]       swRdPtrVal,
  input  logic [IDX_W-1:0]       cfgMaxEntries,
  output logic                   enable,
  output logic [IDX_W-1:0]       wrIdx,
  output logic [IDX_W-1:0]       rdIdx,
  output logic                   stalled,
  output logic                   busy,
  output logic                   memReq,
  output logic [IDX_W+OFF_W-1:0] memAddr,
  input  logic                   memAck,
  input  logic                   memErr,
  input  logic [63:0]            memData,
  output logic                   hStart,
  output logic                   hSel,
  output logic [IDX_W+OFF_W-1:0] hOffset,
  input  logic                   hDone,
  input  logic                   hErr
);
  strb_t                  strb;
  logic                   runReq, outOfRange, qEmpty, opHandled;
  logic [IDX_W+OFF_W-1:0] entryOff;

  cmdq_dpath #(.IDX_W(IDX_W)) u_dpath (
    .clk(clk), .rst_n(rst_n),
    .swEnWr(swEnWr), .swEnVal(swEnVal),
    .swWrPtrWr(swWrPtrWr), .swWrPtrVal(swWrPtrVal),
    .swRdPtrWr(swRdPtrWr), .swRdPtrVal(swRdPtrVal),
    .cfgMaxEntries(cfgMaxEntries), .strb(strb), .memData(memData),
    .enable(enable), .wrIdx(wrIdx), .rdIdx(rdIdx), .stalled(stalled),
    .runReq(runReq), .outOfRange(outOfRange), .qEmpty(qEmpty),
    .opHandled(opHandled), .opSel(hSel), .entryOff(entryOff)
  );

  cmdq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .enable(enable), .stalled(stalled), .runReq(runReq),
    .outOfRange(outOfRange), .qEmpty(qEmpty), .opHandled(opHandled),
    .memAck(memAck), .memErr(memErr), .hDone(hDone), .hErr(hErr),
    .strb(strb), .memReq(memReq), .hStart(hStart), .busy(busy)
  );

  assign memAddr = entryOff;
  assign hOffset = entryOff;
endmodule

// File: tb/cmdq_consumer_tb.sv
module cmdq_consumer_tb;
  localparam int IDX_W  = 8;
  localparam int ADDR_W = IDX_W + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic swEnWr = 0, swEnVal = 0, swWrPtrWr = 0, swRdPtrWr = 0;
  logic [IDX_W-1:0] swWrPtrVal = '0, swRdPtrVal = '0;
  logic [IDX_W-1:0] cfgMaxEntries = 8'd8;
  logic enable, stalled, busy, memReq, hStart, hSel;
  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic [ADDR_W-1:0] memAddr, hOffset;
  logic memAck = 0, memErr = 0, hDone = 0, hErr = 0;
  logic [63:0] memData = '0;

  always #4 clk = ~clk;

  cmdq_consumer #(.IDX_W(IDX_W)) u_dut (.*);

  // memory and handler stubs
  logic [7:0] memOps [0:15];
  int errIdx = -1;
  logic hErrInject = 0;
  int fetchCnt = 0, startCnt = 0, hCnt = 0;
  logic [ADDR_W-1:0] fetchLog [0:15];
  logic [ADDR_W-1:0] startOff [0:15];
  logic startSel [0:15];

  always @(posedge clk) begin
    if (memReq && memAck) begin
      fetchLog[fetchCnt[3:0]] = memAddr;
      fetchCnt = fetchCnt + 1;
    end
    memAck  <= memReq && !memAck;
    memData <= {56'h0, memOps[memAddr[8:5]]};
    memErr  <= (int'(memAddr >> 5) == errIdx);
    if (hStart) begin
      startOff[startCnt[3:0]] = hOffset;
      startSel[startCnt[3:0]] = hSel;
      startCnt = startCnt + 1;
      hCnt = 3;
    end
    hDone <= (hCnt == 1);
    hErr  <= (hCnt == 1) && hErrInject;
    if (hCnt > 0) hCnt = hCnt - 1;
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearLogs();
    fetchCnt = 0;
    startCnt = 0;
  endtask

  task automatic writeWr(int v);
    @(negedge clk);
    swWrPtrWr = 1; swWrPtrVal = IDX_W'(v);
    @(negedge clk);
    swWrPtrWr = 0;
  endtask

  task automatic writeRd(int v);
    @(negedge clk);
    swRdPtrWr = 1; swRdPtrVal = IDX_W'(v);
    @(negedge clk);
    swRdPtrWr = 0;
  endtask

  task automatic waitIdle();
    repeat (4) @(posedge clk);
    for (int i = 0; i < 2000 && busy; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 enable", int'(enable), 0);
    check("R1 rdIdx", int'(rdIdx), 0);
    check("R1 wrIdx", int'(wrIdx), 0);
    check("R1 stalled", int'(stalled), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 memReq", int'(memReq), 0);
    check("R1 hStart", int'(hStart), 0);
  endtask

  task automatic testDisabled();
    clearLogs();
    writeWr(3);
    waitIdle();
    check("R2 no fetch while disabled", fetchCnt, 0);
    check("R2 rdIdx while disabled", int'(rdIdx), 0);
  endtask

  task automatic testEnable();
    writeRd(5);
    check("R12 rdIdx loaded", int'(rdIdx), 5);
    clearLogs();
    @(negedge clk);
    swEnWr = 1; swEnVal = 1;
    @(negedge clk);
    swEnWr = 0;
    check("R3 rdIdx zeroed on enable", int'(rdIdx), 0);
    waitIdle();
    check("R8 rdIdx reaches wrIdx", int'(rdIdx), 3);
    check("R4 fetch count", fetchCnt, 3);
    check("R4 fetch addr 0", int'(fetchLog[0]), 0);
    check("R4 fetch addr 1", int'(fetchLog[1]), 32);
    check("R4 fetch addr 2", int'(fetchLog[2]), 64);
    check("R5 handler starts", startCnt, 2);
    check("R5 dev map sel", int'(startSel[0]), 0);
    check("R5 dev map offset", int'(startOff[0]), 32);
    check("R5 coll map sel", int'(startSel[1]), 1);
    check("R5 coll map offset", int'(startOff[1]), 64);
  endtask

  task automatic testNoops();
    clearLogs();
    writeWr(7);
    waitIdle();
    check("R6 fetches of no-op records", fetchCnt, 4);
    check("R6 no handler start", startCnt, 0);
    check("R6 rdIdx after no-ops", int'(rdIdx), 7);
  endtask

  task automatic testWrap();
    clearLogs();
    writeWr(2);
    waitIdle();
    check("R7 rdIdx after wrap", int'(rdIdx), 2);
    check("R7 fetch before wrap", int'(fetchLog[0]), 224);
    check("R7 fetch after wrap", int'(fetchLog[1]), 0);
    check("R7 handler starts", startCnt, 2);
    check("R7 first sel", int'(startSel[0]), 1);
    check("R7 second offset", int'(startOff[1]), 0);
  endtask

  task automatic testRange();
    clearLogs();
    writeWr(9);
    waitIdle();
    check("R9 no fetch out of range", fetchCnt, 0);
    check("R9 rdIdx kept", int'(rdIdx), 2);
    check("R9 no halt", int'(stalled), 0);
    writeWr(2);
    waitIdle();
    check("R2 equal write no fetch", fetchCnt, 0);
  endtask

  task automatic testMemErr();
    clearLogs();
    errIdx = 4;
    writeWr(6);
    waitIdle();
    check("R10 halted", int'(stalled), 1);
    check("R10 rdIdx on failing record", int'(rdIdx), 4);
    check("R10 fetches", fetchCnt, 3);
    clearLogs();
    writeWr(7);
    waitIdle();
    check("R12 no fetch while halted", fetchCnt, 0);
    check("R12 still halted", int'(stalled), 1);
    errIdx = -1;
    writeRd(4);
    waitIdle();
    check("R12 halt cleared", int'(stalled), 0);
    check("R12 held trigger resumes", int'(rdIdx), 7);
  endtask

  task automatic testHandlerErr();
    clearLogs();
    hErrInject = 1;
    writeWr(0);
    waitIdle();
    check("R11 halted", int'(stalled), 1);
    check("R11 rdIdx on failing record", int'(rdIdx), 7);
    check("R11 handler started", startCnt, 1);
    hErrInject = 0;
    writeRd(0);
    waitIdle();
    check("R12 halt cleared by rd write", int'(stalled), 0);
    check("R12 rdIdx loaded", int'(rdIdx), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) memOps[i] = 8'h05;
    memOps[1] = 8'h08; memOps[2] = 8'h09;
    memOps[3] = 8'h03; memOps[4] = 8'h04; memOps[5] = 8'h0F;
    memOps[6] = 8'hFF; memOps[7] = 8'h09; memOps[0] = 8'h05;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    testReset();
    testDisabled();
    testEnable();
    testNoops();
    memOps[0] = 8'h08; memOps[1] = 8'h0D;
    testWrap();
    testRange();
    memOps[2] = 8'h0C; memOps[3] = 8'h05; memOps[4] = 8'h05;
    testMemErr();
    memOps[7] = 8'h08;
    testHandlerErr();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule